// File: doc/BRIEF.md
# GPIO and Control Register Peripheral

This block is a small bus-attached peripheral. It keeps seven 16-bit control registers, a fixed read-only status word and a 16-line general-purpose I/O port. A host reaches every register through a simple synchronous register bus: address, write strobe and write data, with a combinational read-data return. Only the low six address bits select a register, so one 64-byte window repeats across the whole address region.

The I/O port has a direction register and a level register. An output line shows its level bit only while its direction bit is set. The driven value is recomputed, and a one-cycle per-line change pulse is raised, only when the host writes the direction or the level. Input pins pass through a register stage. A pin that changes then sets or clears its own level bit whatever the direction, and the driven outputs stay as they are until the next host update. One control register has a side effect: a write with bit 7 set also turns on bits 15 and 6.

Top module: `ctlgpio_block`

## Requirements
- R1: After reset every readable register reads 0x0000 except the status word (offset 0x08), which reads 0x0002. `pin_out` and `pin_chg` are 0.
- R2: The six plain registers at word offsets 0x00, 0x04, 0x10, 0x14, 0x18 and 0x1C store the low 16 bits of `bus_wdata` when written and read them back unchanged. Upper data bits are dropped.
- R3: Decode uses only `bus_addr[5:0]`. An address with other upper bits reaches the same register as its low six bits.
- R4: A write to the power register (offset 0x0C) stores the low 16 data bits. If data bit 7 is 1, bits 15 and 6 are also stored as 1, which is the written value ORed with 0x8040.
- R5: The status word at offset 0x08 always reads 0x0002. Writes to it change no register.
- R6: A write to offset 0x24 or 0x28 stores (low 16 data bits AND direction) as the level. A read of either offset returns the level.
- R7: Offset 0x20 holds the direction. `pin_out` equals level AND direction, and it is updated at the same clock edge as any direction or level write.
- R8: A change on a `pin_in` line is registered once. It then sets or clears that level bit at the second rising edge after the change, whatever the direction, and leaves `pin_out` unchanged.
- R9: `pin_chg` is high for exactly one cycle after a direction or level write, on the lines where the new `pin_out` differs from the old one. Otherwise it is zero.
- R10: Offsets 0x2C to 0x3C, and any offset whose two low address bits are not zero, read 0x0000. Writes there change no register.
- R11: A level write and a pin change that reach the level register at the same edge resolve in favour of the bus write, and the pin change is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address; low 6 bits decoded |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data; low 16 bits used |
| bus_rdata | output | 16 | Combinational read data |
| pin_in | input | 16 | I/O input lines |
| pin_out | output | 16 | Driven output lines (level AND direction) |
| pin_chg | output | 16 | One-cycle per-line change pulse |

## Verification
The masking is driven with a split direction of 0x00FF, with an all-ones level and with an alternating 0x0F0F level. This separates a level store that masks by direction from a driven value that only masks at the output. The direction is then flipped while the level is held, which shows whether the outputs are recomputed on a direction write and not only on a level write. Pin changes are applied while no host write is pending, so a design that recomputes outputs on pin activity shows itself. One pin change is timed to land on the same edge as a level write, and the result is compared with both possible winners to confirm the priority. The power register is written with bit 7 set, with it clear, and with garbage above bit 15, to separate the forced bits from plain storage.

// File: rtl/ctlgpio_pkg.sv
package ctlgpio_pkg;
  localparam int unsigned WIN_W  = 6;
  localparam int unsigned NPLAIN = 7;
  localparam int unsigned PWR_IDX = 2;
  localparam int unsigned PWR_TRIG_BIT = 7;
  localparam logic [15:0] PWR_FORCE_MASK = 16'h8040;

  localparam logic [WIN_W-1:0] OFS_STAT = 6'h08;
  localparam logic [WIN_W-1:0] OFS_GDIR = 6'h20;
  localparam logic [WIN_W-1:0] OFS_GLV0 = 6'h24;
  localparam logic [WIN_W-1:0] OFS_GLV1 = 6'h28;

  typedef struct packed {
    logic [NPLAIN-1:0] plain;
    logic              stat;
    logic              dir;
    logic              lvl;
  } dec_t;

  // storage order: mode, card-detect, power, card-control, irq-req, irq-mask, irq-status
  function automatic logic [WIN_W-1:0] plain_ofs(input int unsigned idx);
    case (idx)
      0: plain_ofs = 6'h00;
      1: plain_ofs = 6'h04;
      2: plain_ofs = 6'h0C;
      3: plain_ofs = 6'h10;
      4: plain_ofs = 6'h14;
      5: plain_ofs = 6'h18;
      default: plain_ofs = 6'h1C;
    endcase
  endfunction
endpackage

// File: rtl/ctlgpio_decode.sv
module ctlgpio_decode
  import ctlgpio_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input  logic [AW-1:0] addr,
  output dec_t          dec
);
  logic [WIN_W-1:0] win;
  assign win = addr[WIN_W-1:0];

  for (genvar i = 0; i < NPLAIN; i++) begin : g_hit
    assign dec.plain[i] = (win == plain_ofs(i));
  end

  assign dec.stat = (win == OFS_STAT);
  assign dec.dir  = (win == OFS_GDIR);
  assign dec.lvl  = (win == OFS_GLV0) || (win == OFS_GLV1);

  logic unused_hi;
  if (AW > WIN_W) begin : g_hi
    assign unused_hi = ^addr[AW-1:WIN_W];
  end else begin : g_nohi
    assign unused_hi = 1'b0;
  end
endmodule

// File: rtl/ctlgpio_ctlregs.sv
module ctlgpio_ctlregs
  import ctlgpio_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [NPLAIN-1:0]          hit,
  input  logic [DW-1:0]              wdata,
  output logic [NPLAIN-1:0][DW-1:0]  regs
);
  localparam logic [DW-1:0] FORCE = DW'(PWR_FORCE_MASK);

  for (genvar i = 0; i < NPLAIN; i++) begin : g_reg
    logic [DW-1:0] q;
    logic [DW-1:0] d;
    logic          en;

    assign en = we && hit[i];

    if (i == PWR_IDX) begin : g_pwr
      always_comb begin
        d = wdata;
        if (wdata[PWR_TRIG_BIT]) d = wdata | FORCE;
      end
    end else begin : g_plain
      always_comb d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign regs[i] = q;
  end
endmodule

// File: rtl/ctlgpio_port.sv
module ctlgpio_port #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir_we,
  input  logic         lvl_we,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] dir_q,
  output logic [N-1:0] lvl_q,
  output logic [N-1:0] out_q,
  output logic [N-1:0] chg_q
);
  logic [N-1:0] in_q, in_prev;
  logic [N-1:0] in_evt, lvl_pin, lvl_d, dir_d, drv, out_d, chg_d;
  logic         eval;

  // input stage: one register, then edge-detect against the previous sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q    <= '0;
      in_prev <= '0;
    end else begin
      in_q    <= pin_in;
      in_prev <= in_q;
    end
  end

  always_comb begin
    in_evt  = in_q ^ in_prev;
    lvl_pin = (lvl_q & ~in_evt) | (in_q & in_evt);
    lvl_d   = lvl_we ? (wdata & dir_q) : lvl_pin;
    dir_d   = dir_we ? wdata : dir_q;
    eval    = dir_we || lvl_we;
    drv     = lvl_d & dir_d;
    out_d   = eval ? drv : out_q;
    chg_d   = eval ? (drv ^ out_q) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      lvl_q <= '0;
      out_q <= '0;
      chg_q <= '0;
    end else begin
      if (dir_we) dir_q <= dir_d;
      lvl_q <= lvl_d;
      if (eval)   out_q <= out_d;
      chg_q <= chg_d;
    end
  end
endmodule

// File: rtl/ctlgpio_block.sv
module ctlgpio_block
  import ctlgpio_pkg::*;
#(
  parameter int unsigned AW         = 12,
  parameter int unsigned BW         = 32,
  parameter int unsigned DW         = 16,
  parameter int unsigned NGPIO      = 16,
  parameter logic [15:0] STATUS_RST = 16'h0002
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [BW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NGPIO-1:0] pin_in,
  output logic [NGPIO-1:0] pin_out,
  output logic [NGPIO-1:0] pin_chg
);
  localparam logic [DW-1:0] STAT_VAL = DW'(STATUS_RST);

  // reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1  <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      rst_s1  <= 1'b1;
      rst_n_s <= rst_s1;
    end
  end

  logic [DW-1:0] wd;
  assign wd = bus_wdata[DW-1:0];

  logic unused_wd;
  if (BW > DW) begin : g_wd_hi
    assign unused_wd = ^bus_wdata[BW-1:DW];
  end else begin : g_wd_eq
    assign unused_wd = 1'b0;
  end

  dec_t dec;
  ctlgpio_decode #(.AW(AW)) u_dec (
    .addr (bus_addr),
    .dec  (dec)
  );

  logic [NPLAIN-1:0][DW-1:0] regs;
  ctlgpio_ctlregs #(.DW(DW)) u_regs (
    .clk   (clk),
    .rst_n (rst_n_s),
    .we    (bus_we),
    .hit   (dec.plain),
    .wdata (wd),
    .regs  (regs)
  );

  logic [DW-1:0] pwr_q;
  assign pwr_q = regs[PWR_IDX];

  logic [NGPIO-1:0] dir_q, lvl_q;
  ctlgpio_port #(.N(NGPIO)) u_port (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .dir_we (bus_we && dec.dir),
    .lvl_we (bus_we && dec.lvl),
    .wdata  (wd[NGPIO-1:0]),
    .pin_in (pin_in),
    .dir_q  (dir_q),
    .lvl_q  (lvl_q),
    .out_q  (pin_out),
    .chg_q  (pin_chg)
  );

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NPLAIN; i++) begin
      if (dec.plain[i]) bus_rdata = regs[i];
    end
    if (dec.stat) bus_rdata = STAT_VAL;
    if (dec.dir)  bus_rdata = DW'(dir_q);
    if (dec.lvl)  bus_rdata = DW'(lvl_q);
  end
endmodule

// File: rtl/ctlgpio_chk.sv
module ctlgpio_chk #(
  parameter int unsigned AW    = 12,
  parameter int unsigned BW    = 32,
  parameter int unsigned DW    = 16,
  parameter int unsigned NGPIO = 16
) (
  input logic             clk,
  input logic             rst_n_s,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_we,
  input logic [BW-1:0]    bus_wdata,
  input logic [DW-1:0]    bus_rdata,
  input logic [NGPIO-1:0] pin_out,
  input logic [NGPIO-1:0] pin_chg,
  input logic [NGPIO-1:0] dir_q,
  input logic [NGPIO-1:0] lvl_q,
  input logic [DW-1:0]    pwr_q
);
  logic [5:0] w;
  logic       gp_wr, lv_wr, pw_wr;
  assign w     = bus_addr[5:0];
  assign lv_wr = bus_we && (w == 6'h24 || w == 6'h28);
  assign gp_wr = lv_wr || (bus_we && w == 6'h20);
  assign pw_wr = bus_we && (w == 6'h0C);

  assert_status_ro_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (w == 6'h08) |-> (bus_rdata == DW'(16'h0002)));

  assert_out_masked_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (pin_out & ~dir_q) == '0);

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !gp_wr |=> $stable(pin_out));

  assert_chg_diff_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    pin_chg == (pin_out ^ $past(pin_out)));

  assert_chg_cause_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (pin_chg != '0) |-> $past(gp_wr));

  assert_pwr_force_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (pw_wr && bus_wdata[7]) |=> (pwr_q[15] && pwr_q[6] && pwr_q[7]));

  assert_lvl_mask_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    lv_wr |=> ((lvl_q & ~$past(dir_q)) == '0));
endmodule

bind ctlgpio_block ctlgpio_chk #(.AW(AW), .BW(BW), .DW(DW), .NGPIO(NGPIO)) u_chk (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_chg   (pin_chg),
  .dir_q     (dir_q),
  .lvl_q     (lvl_q),
  .pwr_q     (pwr_q)
);

// File: tb/tb_ctlgpio_block.sv
`timescale 1ns/1ps
module tb_ctlgpio_block;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [15:0] pin_in;
  logic [15:0] pin_out;
  logic [15:0] pin_chg;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  ctlgpio_block dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_chg(pin_chg)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 pin_out", pin_out, 16'h0);
    check("R1 pin_chg", pin_chg, 16'h0);
    rd(12'h000, v); check("R1 mode", v, 16'h0);
    rd(12'h00C, v); check("R1 power", v, 16'h0);
    rd(12'h008, v); check("R1 status", v, 16'h0002);
    rd(12'h020, v); check("R1 dir", v, 16'h0);
    rd(12'h024, v); check("R1 level", v, 16'h0);
  endtask

  task automatic t_plain();
    logic [15:0] v;
    wr(12'h000, 32'hABCD_1234); wr(12'h004, 32'h0000_5555);
    wr(12'h010, 32'hFFFF_00F0); wr(12'h014, 32'h0000_0101);
    wr(12'h018, 32'h1234_8001); wr(12'h01C, 32'h0000_7E7E);
    rd(12'h000, v); check("R2 mode", v, 16'h1234);
    rd(12'h004, v); check("R2 cdet", v, 16'h5555);
    rd(12'h010, v); check("R2 cctl", v, 16'h00F0);
    rd(12'h014, v); check("R2 ireq", v, 16'h0101);
    rd(12'h018, v); check("R2 imsk", v, 16'h8001);
    rd(12'h01C, v); check("R2 ists", v, 16'h7E7E);
  endtask

  task automatic t_alias();
    logic [15:0] v;
    wr(12'h050, 32'h0000_C3C3);
    rd(12'h010, v); check("R3 alias write", v, 16'hC3C3);
    rd(12'hFD0, v); check("R3 alias read", v, 16'hC3C3);
  endtask

  task automatic t_power();
    logic [15:0] v;
    wr(12'h00C, 32'h0000_0080); rd(12'h00C, v); check("R4 force", v, 16'h80C0);
    wr(12'h00C, 32'h0000_0041); rd(12'h00C, v); check("R4 plain", v, 16'h0041);
    wr(12'h00C, 32'hFFFF_0081); rd(12'h00C, v); check("R4 upper", v, 16'h80C1);
  endtask

  task automatic t_status();
    logic [15:0] v;
    wr(12'h008, 32'h0000_FFFF);
    rd(12'h008, v); check("R5 status", v, 16'h0002);
    rd(12'h000, v); check("R5 mode kept", v, 16'h1234);
    rd(12'h00C, v); check("R5 power kept", v, 16'h80C1);
  endtask

  task automatic t_undef();
    logic [15:0] v;
    wr(12'h02C, 32'h0000_FFFF); wr(12'h03C, 32'h0000_FFFF); wr(12'h001, 32'h0000_FFFF);
    wr(12'h021, 32'h0000_FFFF);
    rd(12'h02C, v); check("R10 rd 0x2C", v, 16'h0);
    rd(12'h030, v); check("R10 rd 0x30", v, 16'h0);
    rd(12'h001, v); check("R10 rd 0x01", v, 16'h0);
    rd(12'h000, v); check("R10 mode kept", v, 16'h1234);
    rd(12'h020, v); check("R10 dir kept", v, 16'h0);
  endtask

  task automatic t_gpio();
    logic [15:0] v;
    wr(12'h020, 32'h0000_00FF);
    check("R7 out after dir", pin_out, 16'h0000);
    check("R9 no chg", pin_chg, 16'h0000);
    wr(12'h024, 32'h0000_FFFF);
    check("R7 out after lvl", pin_out, 16'h00FF);
    check("R9 chg", pin_chg, 16'h00FF);
    @(negedge clk); check("R9 chg one cycle", pin_chg, 16'h0000);
    rd(12'h028, v); check("R6 level masked", v, 16'h00FF);
    wr(12'h028, 32'h0000_0F0F);
    check("R6 out via 0x28", pin_out, 16'h000F);
    check("R9 chg 0x28", pin_chg, 16'h00F0);
    rd(12'h024, v); check("R6 level", v, 16'h000F);
    wr(12'h020, 32'h0000_FF00);
    check("R7 out on dir flip", pin_out, 16'h0000);
    check("R9 chg dir flip", pin_chg, 16'h000F);
    rd(12'h020, v); check("R7 dir read", v, 16'hFF00);
  endtask

  task automatic t_pins();
    logic [15:0] v;
    @(negedge clk); pin_in = 16'h8001;
    repeat (2) @(negedge clk);
    check("R8 out unchanged", pin_out, 16'h0000);
    check("R8 no chg", pin_chg, 16'h0000);
    rd(12'h024, v); check("R8 pin set", v, 16'h800F);
    wr(12'h020, 32'h0000_FFFF);
    check("R7 out new dir", pin_out, 16'h800F);
    check("R9 chg new dir", pin_chg, 16'h800F);
    @(negedge clk); pin_in = 16'h0000;
    repeat (2) @(negedge clk);
    rd(12'h028, v); check("R8 pin clear", v, 16'h000E);
    check("R8 out held", pin_out, 16'h800F);
  endtask

  task automatic t_priority();
    logic [15:0] v;
    wr(12'h020, 32'h0000_00FF);
    check("R9 chg dir", pin_chg, 16'h8001);
    @(negedge clk); pin_in = 16'h8000;
    @(negedge clk); bus_addr = 12'h024; bus_wdata = 32'h0000_0F0F; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    rd(12'h024, v); check("R11 bus wins", v, 16'h000F);
    repeat (3) @(negedge clk);
    rd(12'h024, v); check("R11 pin dropped", v, 16'h000F);
    check("R11 out", pin_out, 16'h000F);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_plain();
    t_alias();
    t_power();
    t_status();
    t_undef();
    t_gpio();
    t_pins();
    t_priority();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule